// File: doc/BRIEF.md
# Load-Store Integer Core

A small single-issue integer processor that runs a reduced 64-bit load-store instruction set. Every instruction word is 32 bits. The core takes exactly two clock cycles per instruction. In the first cycle it latches the word at the current program counter from the instruction port. In the second it decodes and executes that word, which may include one data-memory access, and it updates the program counter. Arithmetic works only on registers and a sign-extended 16-bit immediate. Only the load and store instructions use the data port.

Both memory ports are read combinationally: the surrounding system returns the addressed word in the same cycle. Stores are committed on the rising edge that ends the execute cycle. The register file holds 32 entries of 64 bits. Entry 0 is tied to zero and entry 31 receives the return address on a linking jump. There are no condition flags: the only conditional branch tests one register against zero. When the core decodes an instruction it does not know, it raises `illegal` and stops until the next reset.

Top module: `lsc_core`

## Requirements
- R1: There are 32 registers of 64 bits. Register 0 always reads as zero, and writes to it are discarded.
- R2: The instruction fields sit at fixed positions: opcode in [31:26], rs in [25:21], rt in [20:16], rd in [15:11], function in [5:0]. The 16-bit immediate in [15:0] is sign-extended to 64 bits. A memory address is rs plus the extended immediate.
- R3: Opcode 0x00 with function 0x2D writes rs+rt, modulo 2^64 and with no trap, into rd.
- R4: Opcode 0x19 writes rs plus the sign-extended immediate into rt.
- R5: Opcode 0x37 loads the 64-bit data word at rs+imm into rt and does not write memory. A register-indirect access is the same instruction with an immediate of 0.
- R6: Opcode 0x3F stores rt at rs+imm. In its execute cycle it drives dmem_we=1, dmem_addr and dmem_wdata. No other instruction or cycle raises dmem_we.
- R7: Opcode 0x04 branches when rs equals zero, to PC+4+(imm<<2). When rs is not zero the next PC is PC+4.
- R8: Opcode 0x00 with function 0x08 sets PC to the value of rs and writes no register.
- R9: Opcode 0x00 with function 0x09 writes PC+4 into register 31 and sets PC to the value rs held before that write, including when rs is 31.
- R10: Each instruction takes one fetch cycle and one execute cycle, and imem_addr always shows the PC. During reset, imem_addr=0, dmem_we=0 and illegal=0. The first fetch completes on the third rising edge after rst_n is released.
- R11: An undefined opcode, or an undefined function under opcode 0x00, raises illegal from the next cycle on. The PC then holds, no store is issued, and the core stays in this state until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 64 | Byte address of the instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 64 | Byte address of the data access |
| dmem_wdata | output | 64 | Store data |
| dmem_we | output | 1 | Store strobe, taken on the rising edge |
| dmem_rdata | input | 64 | Data word at dmem_addr, same cycle |
| illegal | output | 1 | Undefined instruction seen; core halted |

## Verification
The embedded properties hold on every cycle. They check that a register index of zero reads zero, and that the store strobe appears only while a store is executing. They also check that a fetch cycle leaves the PC alone and that a not-taken zero test advances it by four. A halted core must stay halted with a frozen PC. The arithmetic results, load data, the taken-branch and jump targets, the return-address value and the old-value rule for a jump through register 31 are not visible on any single cycle. Only the scenarios show them, by comparing every PC and every store against an instruction-level model over directed and randomized programs.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h19;
  localparam logic [5:0] OP_LD   = 6'h37;
  localparam logic [5:0] OP_SD   = 6'h3F;

  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;
  localparam logic [5:0] FN_ADDU = 6'h2D;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;
  typedef enum logic [2:0] {K_ADDU, K_ADDI, K_LD, K_SD, K_BEQZ, K_JR, K_JALR, K_ILL} kind_e;
endpackage

// File: rtl/lsc_regfile.sv
`timescale 1ns/1ps
module lsc_regfile #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREG];

  // entry 0 is never written; its reads are masked below (R1)
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/lsc_decode.sv
`timescale 1ns/1ps
module lsc_decode
  import lsc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [ILEN-1:0]   ir,
  output kind_e             kind,
  output logic [RIDX_W-1:0] rs,
  output logic [RIDX_W-1:0] rt,
  output logic [RIDX_W-1:0] rd,
  output logic [XLEN-1:0]   simm
);
  logic [5:0] opc;
  logic [5:0] fnc;

  assign opc  = ir[31:26];
  assign fnc  = ir[5:0];
  assign rs   = ir[25:21];
  assign rt   = ir[20:16];
  assign rd   = ir[15:11];
  assign simm = {{(XLEN-16){ir[15]}}, ir[15:0]};

  always_comb begin
    kind = K_ILL;
    unique case (opc)
      OP_REG: begin
        unique case (fnc)
          FN_ADDU: kind = K_ADDU;
          FN_JR:   kind = K_JR;
          FN_JALR: kind = K_JALR;
          default: kind = K_ILL;
        endcase
      end
      OP_ADDI: kind = K_ADDI;
      OP_LD:   kind = K_LD;
      OP_SD:   kind = K_SD;
      OP_BEQZ: kind = K_BEQZ;
      default: kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/lsc_exec.sv
`timescale 1ns/1ps
module lsc_exec
  import lsc_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  kind_e           kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] simm,
  input  logic [AW-1:0]   rt,
  input  logic [AW-1:0]   rd,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] npc,
  output logic            wb_en,
  output logic [AW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] mem_addr,
  output logic            st_en
);
  localparam logic [AW-1:0] LINK_IDX = AW'(NREG - 1);

  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] eff;

  assign pc_seq   = pc + XLEN'(4);
  assign eff      = rs_val + simm;
  assign mem_addr = eff;

  always_comb begin
    npc     = pc_seq;
    wb_en   = 1'b0;
    wb_idx  = rt;
    wb_data = eff;
    st_en   = 1'b0;
    unique case (kind)
      K_ADDU: begin wb_en = 1'b1; wb_idx = rd; wb_data = rs_val + rt_val; end
      K_ADDI: begin wb_en = 1'b1; end
      K_LD:   begin wb_en = 1'b1; wb_data = ld_data; end
      K_SD:   begin st_en = 1'b1; end
      K_BEQZ: begin
        if (rs_val == '0) npc = pc_seq + (simm << 2);
      end
      K_JR:   begin npc = rs_val; end
      K_JALR: begin
        npc = rs_val; wb_en = 1'b1; wb_idx = LINK_IDX; wb_data = pc_seq;
      end
      default: npc = pc;
    endcase
  end
endmodule

// File: rtl/lsc_core.sv
`timescale 1ns/1ps
module lsc_core
  import lsc_pkg::*;
#(
  parameter int unsigned XW = lsc_pkg::XLEN,
  parameter int unsigned NR = lsc_pkg::NREG
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XW-1:0]   imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XW-1:0]   dmem_addr,
  output logic [XW-1:0]   dmem_wdata,
  output logic            dmem_we,
  input  logic [XW-1:0]   dmem_rdata,
  output logic            illegal
);
  localparam int unsigned AW = $clog2(NR);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  state_e          state_q, state_d;
  logic [XW-1:0]   pc_q, pc_d;
  logic [ILEN-1:0] ir_q, ir_d;
  logic            pc_en, ir_en, exec_en;

  kind_e           dec_kind;
  logic [AW-1:0]   dec_rs, dec_rt, dec_rd;
  logic [XW-1:0]   dec_simm;
  logic [XW-1:0]   rs_val, rt_val;
  logic [XW-1:0]   x_npc, x_wb_data, x_mem_addr;
  logic            x_wb_en, x_st_en;
  logic [AW-1:0]   x_wb_idx;

  lsc_decode #(.XLEN(XW)) u_dec (
    .ir(ir_q), .kind(dec_kind), .rs(dec_rs), .rt(dec_rt), .rd(dec_rd), .simm(dec_simm)
  );

  lsc_regfile #(.XLEN(XW), .NREG(NR)) u_rf (
    .clk(clk), .we(exec_en && x_wb_en), .waddr(x_wb_idx), .wdata(x_wb_data),
    .raddr_a(dec_rs), .rdata_a(rs_val), .raddr_b(dec_rt), .rdata_b(rt_val)
  );

  lsc_exec #(.XLEN(XW), .NREG(NR)) u_exe (
    .kind(dec_kind), .pc(pc_q), .rs_val(rs_val), .rt_val(rt_val), .simm(dec_simm),
    .rt(dec_rt), .rd(dec_rd), .ld_data(dmem_rdata), .npc(x_npc), .wb_en(x_wb_en),
    .wb_idx(x_wb_idx), .wb_data(x_wb_data), .mem_addr(x_mem_addr), .st_en(x_st_en)
  );

  assign exec_en = (state_q == ST_EXEC);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    unique case (state_q)
      ST_FETCH: begin ir_d = imem_rdata; ir_en = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        if (dec_kind == K_ILL) begin
          state_d = ST_HALT;
        end else begin
          state_d = ST_FETCH; pc_d = x_npc; pc_en = 1'b1;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = x_mem_addr;
  assign dmem_wdata = rt_val;
  assign dmem_we    = exec_en && x_st_en;
  assign illegal    = (state_q == ST_HALT);

  a_r1_zero_reads: assert property (@(posedge clk) disable iff (!rst_i)
    (dec_rs == '0) |-> (rs_val == '0));
  a_r6_store_only_exec: assert property (@(posedge clk) disable iff (!rst_i)
    dmem_we |-> (state_q == ST_EXEC && dec_kind == K_SD));
  a_r7_not_taken_seq: assert property (@(posedge clk) disable iff (!rst_i)
    (exec_en && dec_kind == K_BEQZ && rs_val != '0) |=> (pc_q == $past(pc_q) + XW'(4)));
  a_r10_fetch_holds_pc: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_FETCH) |=> ($stable(pc_q) && state_q == ST_EXEC));
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    illegal |=> (illegal && $stable(pc_q) && !dmem_we));
endmodule

// File: tb/lsc_core_tb.sv
`timescale 1ns/1ps
module lsc_core_tb;
  localparam logic [5:0] O_REG = 6'h00, O_BEQZ = 6'h04, O_ADDI = 6'h19;
  localparam logic [5:0] O_LD = 6'h37, O_SD = 6'h3F, O_BAD = 6'h3E;
  localparam logic [5:0] F_JR = 6'h08, F_JALR = 6'h09, F_ADDU = 6'h2D, F_BAD = 6'h3A;
  localparam int B = 15;
  localparam int RSTART = B + 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] imem_rdata;
  logic        dmem_we, illegal;

  always #10 clk = ~clk;

  lsc_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  logic [31:0] imem [64];
  logic [63:0] dmem [32];
  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:3]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:3]] <= dmem_wdata;

  // instruction-level model
  logic [63:0] mreg [32];
  string       msrc [32];
  logic [63:0] mmem [32];
  logic [63:0] mpc;
  bit          mhalt;
  bit          e_we;
  logic [63:0] e_addr, e_wdata;
  string       e_req_pc, e_req_data;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ei(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] er(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {O_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] rand_instr();
    int sel = $urandom_range(0, 5);
    int d = $urandom_range(4, 15);
    int s = $urandom_range(0, 15);
    int t = $urandom_range(0, 15);
    case (sel)
      0: return er(F_ADDU, d, s, t);
      1: return ei(O_ADDI, d, s, 16'($urandom));
      2: return ei(O_SD, t, 0, 16'($urandom_range(0, 31) * 8));
      3: return ei(O_LD, d, 0, 16'($urandom_range(0, 31) * 8));
      4: return ei(O_SD, t, 2, 16'($urandom_range(0, 15) * 8));
      default: return ei(O_BEQZ, 0, s, 16'($urandom_range(0, 2)));
    endcase
  endfunction

  task automatic build_prog(input bit bad_funct);
    for (int i = 0; i < 64; i++) imem[i] = {O_BAD, 26'd0};
    for (int r = 1; r < 16; r++) imem[r-1] = ei(O_ADDI, r, 0, 16'($urandom));
    imem[B+0]  = ei(O_ADDI, 2, 0, 16'd64);
    imem[B+1]  = ei(O_ADDI, 3, 0, 16'd200);
    imem[B+2]  = ei(O_ADDI, 0, 0, 16'd5);          // R1: write to r0 dropped
    imem[B+3]  = ei(O_SD, 0, 2, 16'd0);
    imem[B+4]  = ei(O_ADDI, 4, 0, 16'(-3));        // R4: negative immediate
    imem[B+5]  = ei(O_SD, 4, 3, 16'(-16));         // R2: negative displacement
    imem[B+6]  = ei(O_LD, 5, 3, 16'(-16));
    imem[B+7]  = ei(O_LD, 6, 2, 16'd0);            // R5: register-indirect
    imem[B+8]  = er(F_ADDU, 7, 5, 4);
    imem[B+9]  = ei(O_SD, 7, 2, 16'd8);
    imem[B+10] = ei(O_BEQZ, 0, 6, 16'd1);          // R7: taken
    imem[B+11] = ei(O_SD, 4, 0, 16'd0);
    imem[B+12] = ei(O_BEQZ, 0, 5, 16'd1);          // R7: not taken
    imem[B+13] = ei(O_SD, 5, 0, 16'd16);
    imem[B+14] = ei(O_ADDI, 8, 0, 16'(4*(B+18)));
    imem[B+15] = er(F_JALR, 0, 8, 0);              // R9
    imem[B+16] = ei(O_SD, 31, 0, 16'd24);
    imem[B+17] = ei(O_BEQZ, 0, 0, 16'd2);
    imem[B+18] = ei(O_SD, 8, 0, 16'd32);
    imem[B+19] = er(F_JALR, 0, 31, 0);             // R9: rs is the link register
    imem[B+20] = ei(O_ADDI, 9, 0, 16'(4*(B+23)));
    imem[B+21] = er(F_JR, 0, 9, 0);                // R8
    imem[B+22] = ei(O_SD, 9, 0, 16'd40);
    for (int i = RSTART; i < 61; i++) imem[i] = rand_instr();
    imem[61] = bad_funct ? er(F_BAD, 0, 0, 0) : {O_BAD, 26'd0};
  endtask

  task automatic model_exec();
    logic [31:0] ins;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, wi;
    logic [63:0] simm, rsv, rtv, ea, npc, wv;
    bit          wr;
    string       wtag;
    ins  = imem[mpc[7:2]];
    op   = ins[31:26]; fn = ins[5:0];
    rs   = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    simm = {{48{ins[15]}}, ins[15:0]};
    rsv  = mreg[rs]; rtv = mreg[rt];
    ea   = rsv + simm;
    npc  = mpc + 64'd4;
    wr = 0; wi = '0; wv = '0; wtag = "";
    e_we = 0; e_addr = '0; e_wdata = '0; e_req_pc = "R10"; e_req_data = "R6";
    case (op)
      O_REG: begin
        case (fn)
          F_ADDU: begin wr = 1; wi = rd; wv = rsv + rtv; wtag = "R3"; end
          F_JR:   begin npc = rsv; e_req_pc = "R8"; end
          F_JALR: begin wr = 1; wi = 5'd31; wv = mpc + 64'd4; wtag = "R9"; npc = rsv; e_req_pc = "R9"; end
          default: mhalt = 1;
        endcase
      end
      O_ADDI: begin wr = 1; wi = rt; wv = ea; wtag = "R4"; end
      O_LD:   begin wr = 1; wi = rt; wv = mmem[ea[7:3]]; wtag = "R5"; end
      O_SD:   begin
        e_we = 1; e_addr = ea; e_wdata = rtv; e_req_data = msrc[rt];
        mmem[ea[7:3]] = rtv;
      end
      O_BEQZ: begin
        e_req_pc = "R7";
        if (rsv == 64'd0) npc = mpc + 64'd4 + (simm << 2);
      end
      default: mhalt = 1;
    endcase
    if (wr && wi != 5'd0) begin mreg[wi] = wv; msrc[wi] = wtag; end
    if (!mhalt) mpc = npc;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(imem_addr === 64'd0, "R10", imem_addr, 64'd0);
    chk(dmem_we === 1'b0, "R10", 64'(dmem_we), 64'd0);
    chk(illegal === 1'b0, "R10", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run_prog(input int maxi);
    int    n;
    string pc_req;
    n = 0; pc_req = "R10"; mhalt = 0; mpc = '0;
    while (!mhalt && n < maxi) begin
      @(negedge clk);                           // fetch cycle
      chk(imem_addr === mpc, pc_req, imem_addr, mpc);
      chk(dmem_we === 1'b0, "R6", 64'(dmem_we), 64'd0);
      @(negedge clk);                           // execute cycle
      model_exec();
      chk(illegal === 1'b0, "R11", 64'(illegal), 64'd0);
      chk(dmem_we === e_we, "R6", 64'(dmem_we), 64'(e_we));
      if (e_we) begin
        chk(dmem_addr === e_addr, "R2", dmem_addr, e_addr);
        chk(dmem_wdata === e_wdata, e_req_data, dmem_wdata, e_wdata);
      end
      pc_req = e_req_pc;
      n++;
    end
    repeat (3) begin
      @(negedge clk);
      chk(illegal === 1'b1, "R11", 64'(illegal), 64'd1);
      chk(imem_addr === mpc, "R11", imem_addr, mpc);
      chk(dmem_we === 1'b0, "R11", 64'(dmem_we), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin
      mreg[i] = '0;
      msrc[i] = "R1";
      mmem[i] = {$urandom, $urandom};
      dmem[i] = mmem[i];
    end
    build_prog(1'b0);
    do_reset();
    run_prog(400);
    build_prog(1'b1);
    do_reset();
    run_prog(400);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule